// File: doc/BRIEF.md
# Expansion Bus Clock Divider with Reference Fallback

This block makes the expansion bus clock from the CPU bus clock. A 3-bit select code picks one of seven divide ratios. The set is not monotonic and mixes even and odd values. The eighth code stops division and hands the output to an externally timed reference, which arrives as a single-cycle tick enable. The block drives a level that follows the bus clock waveform, a one-cycle strobe in the first high cycle of every output period, and a flag that tells which source is driving.

A configuration write presents a code together with a one-cycle write strobe. The code is held as pending and is applied only when the running output period has completed. A change of ratio or source therefore never cuts a high or low phase short. After reset the reference drives the output until a code has been written and applied.

Top module: `busclk_div`

## Requirements
- R1: After reset, refActive is 1, busClk is 0 and busTick is 0, and the reference stays the source for as long as no code is written.
- R2: Divide codes give an output period, counted in CPU clock cycles from one busTick to the next, of: code 000 → 2, 001 → 4, 010 → 8, 100 → 3, 101 → 6, 110 → 5, 111 → 10.
- R3: In divide mode each period starts with floor(N/2) high cycles and ends with ceil(N/2) low cycles. busTick is 1 only in the first high cycle, so for odd N the high phase is one cycle shorter than the low phase.
- R4: Code 011 selects the reference. In that mode every refTick sampled at a clock edge flips busClk at that edge, and busTick is 1 in each cycle where busClk has just gone from 0 to 1.
- R5: A written code is applied only at the clock edge that ends the current output period. In divide mode that is the edge after the last low cycle. In reference mode it is an edge that samples refTick while busClk is 0. A code captured at that same edge waits for the following period end.
- R6: If several codes are written before a period end, only the last one is applied.
- R7: When a divide code is applied, the new period starts in the very next cycle with busTick and busClk both 1, and the counter begins from zero.
- R8: refActive is 1 exactly while the reference is the source. After a switch to the reference it is 1 from the first cycle after the period end, with busClk at 0.
- R9: In reference mode, busClk does not change and the block stays in reference mode across any clock edge at which refTick is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | Single-cycle enable marking each half period of the fixed reference |
| selWr | input | 1 | Write strobe for selCode |
| selCode | input | 3 | Divide or source select code |
| busClk | output | 1 | Bus clock waveform level |
| busTick | output | 1 | Strobe in the first high cycle of each output period |
| refActive | output | 1 | 1 while the reference is the source |

## Verification
The bench measures both the period and the high-phase length of every divide code. A decode that swapped the table's odd and even entries would show up as the wrong period, and a duty rule rounded the wrong way would show up on ratios 3 and 5. Writes are placed in the middle of a period and in its last cycle. A design that applied codes at once would produce a short period, and one that compared against the incoming strobe instead of the held code would switch one period early. Back-to-back writes show whether a stale pending code survives. The switches into and out of the reference, with refTick held low, show whether the design leaves the reference before a low-phase tick or lets busClk drift without one.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 4;
  localparam logic [SEL_W-1:0] REF_CODE = 3'b011;

  typedef struct packed {
    logic             apply;
    logic             toRef;
    logic [CNT_W-1:0] ratio;
  } ctrlStrobe_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'b000:  r = CNT_W'(2);
      3'b001:  r = CNT_W'(4);
      3'b010:  r = CNT_W'(8);
      3'b100:  r = CNT_W'(3);
      3'b101:  r = CNT_W'(6);
      3'b110:  r = CNT_W'(5);
      3'b111:  r = CNT_W'(10);
      default: r = CNT_W'(2);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/busclk_ctrl.sv
module busclk_ctrl
  import busclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selCode,
  input  logic             boundary,
  output ctrlStrobe_t      strobe
);
  logic             pendValid;
  logic [SEL_W-1:0] pendCode;

  // held code is applied when the datapath reports a period end
  always_comb begin
    strobe.apply = pendValid && boundary;
    strobe.toRef = (pendCode == REF_CODE);
    strobe.ratio = ratioOf(pendCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendCode  <= REF_CODE;
    end else begin
      if (strobe.apply) pendValid <= 1'b0;
      if (selWr) begin
        pendValid <= 1'b1;
        pendCode  <= selCode;
      end
    end
  end
endmodule

// File: rtl/busclk_dp.sv
module busclk_dp
  import busclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  ctrlStrobe_t strobe,
  output logic        boundary,
  output logic        busTick,
  output logic        busClk,
  output logic        refActive
);
  logic             refMode;
  logic [CNT_W-1:0] ratioQ;
  logic [CNT_W-1:0] cnt;
  logic             lowPh;    // reference mode: 1 while in the low half
  logic             startQ;   // reference mode: first high cycle
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] halfCnt;

  assign lastCnt = ratioQ - CNT_W'(1);
  assign halfCnt = ratioQ >> 1;

  always_comb begin
    if (refMode) boundary = refTick && lowPh;
    else         boundary = (cnt == lastCnt);
  end

  assign busTick   = refMode ? startQ : (cnt == '0);
  assign busClk    = refMode ? ~lowPh : (cnt < halfCnt);
  assign refActive = refMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refMode <= 1'b1;
      ratioQ  <= CNT_W'(2);
      cnt     <= '0;
      lowPh   <= 1'b1;
      startQ  <= 1'b0;
    end else if (strobe.apply) begin
      refMode <= strobe.toRef;
      ratioQ  <= strobe.ratio;
      cnt     <= '0;
      // staying on the reference continues into its high half
      lowPh   <= strobe.toRef ? !refMode : 1'b1;
      startQ  <= strobe.toRef && refMode;
    end else if (refMode) begin
      if (refTick) lowPh <= ~lowPh;
      startQ <= refTick && lowPh;
    end else begin
      cnt    <= (cnt == lastCnt) ? '0 : cnt + CNT_W'(1);
      startQ <= 1'b0;
    end
  end
endmodule

// File: rtl/busclk_div.sv
module busclk_div
  import busclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selCode,
  output logic             busClk,
  output logic             busTick,
  output logic             refActive
);
  ctrlStrobe_t strobe;
  logic        boundary;

  busclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selWr(selWr), .selCode(selCode),
    .boundary(boundary), .strobe(strobe)
  );

  busclk_dp u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .strobe(strobe),
    .boundary(boundary), .busTick(busTick), .busClk(busClk),
    .refActive(refActive)
  );
endmodule

// File: rtl/busclk_chk.sv
module busclk_chk (
  input logic clk,
  input logic rstN,
  input logic refTick,
  input logic busTick,
  input logic busClk,
  input logic refActive
);
  // R3: the strobe only marks a high cycle
  a_r3_tick_in_high: assert property (@(posedge clk) disable iff (!rstN)
    busTick |-> busClk);

  // R3: every rising edge of the waveform carries the strobe
  a_r3_rise_has_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busClk) |-> busTick);

  // R2: divided periods are at least two cycles long
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (busTick && !refActive) |=> !busTick);

  // R9: without a reference tick nothing moves in reference mode
  a_r9_ref_hold: assert property (@(posedge clk) disable iff (!rstN)
    (refActive && !refTick) |=> ($stable(busClk) && refActive));

  // R8: a source switch lands on a period boundary
  a_r8_switch_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refActive) |-> (refActive ? (!busClk && !busTick) : busTick));
endmodule

bind busclk_div busclk_chk u_chk (
  .clk(clk), .rstN(rstN), .refTick(refTick), .busTick(busTick),
  .busClk(busClk), .refActive(refActive)
);

// File: tb/sim_busclk_div.sv
module sim_busclk_div;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       selWr = 1'b0;
  logic [2:0] selCode = 3'b000;
  logic       busClk, busTick, refActive;

  int errors = 0;
  int checks = 0;
  int cycN = 0;
  bit refAuto = 1'b0;
  bit refForce = 1'b0;

  busclk_div u0 (
    .clk(clk), .rstN(rstN), .refTick(refTick), .selWr(selWr),
    .selCode(selCode), .busClk(busClk), .busTick(busTick),
    .refActive(refActive)
  );

  always #4 clk = ~clk;

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic cyc();
    @(posedge clk);
    #1;
    cycN++;
    refTick = refForce | (refAuto && (cycN % 5 == 0));
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] c);
    selWr = 1'b1;
    selCode = c;
    cyc();
    selWr = 1'b0;
  endtask

  function automatic int ratio(input int c);
    case (c)
      0: return 2;
      1: return 4;
      2: return 8;
      4: return 3;
      5: return 6;
      6: return 5;
      7: return 10;
      default: return 0;
    endcase
  endfunction

  task automatic gapToTick(output int g);
    g = 0;
    for (int i = 0; i < 300; i++) begin
      cyc();
      g++;
      if (busTick) break;
    end
  endtask

  task automatic waitDivTick();
    for (int i = 0; i < 300; i++) begin
      cyc();
      if (busTick && !refActive) break;
    end
  endtask

  task automatic measure(input int n);
    int g;
    int h;
    g = 0;
    h = 0;
    for (int i = 0; i < 300; i++) begin
      if (busClk) h++;
      cyc();
      g++;
      if (busTick) break;
    end
    chk("R2 period", g, n);
    chk("R3 high cycles", h, n / 2);
    chk("R8 divided source flag", refActive, 0);
  endtask

  initial begin
    int g;
    int codes[7] = '{0, 4, 1, 6, 5, 2, 7};
    repeat (3) cyc();
    chk("R1 reset refActive", refActive, 1);
    chk("R1 reset busClk", busClk, 0);
    chk("R1 reset busTick", busTick, 0);
    rstN = 1'b1;
    refAuto = 1'b1;
    cyc();

    // R4, R9: reference mode waveform follows refTick
    for (int i = 0; i < 30; i++) begin
      logic pClk, pRef;
      pClk = busClk;
      pRef = refTick;
      cyc();
      chk("R4 ref toggle", busClk, pClk ^ pRef);
      chk("R4 ref tick", busTick, busClk && !pClk);
      chk("R1 stays on reference", refActive, 1);
    end

    // R2, R3: sweep of every divide code
    foreach (codes[k]) begin
      wr(codes[k][2:0]);
      waitDivTick();
      waitDivTick();
      measure(ratio(codes[k]));
      measure(ratio(codes[k]));
    end

    // R5: write captured at the period-ending edge waits one period (ratio 10 -> 6)
    waitDivTick();
    repeat (9) cyc();
    wr(3'b101);
    chk("R5 old tick at boundary", busTick, 1);
    gapToTick(g);
    chk("R5 last-cycle write deferred", g, 10);
    gapToTick(g);
    chk("R7 new ratio after deferral", g, 6);

    // R6: last of two writes wins (ratio 6 -> 4, not 10)
    waitDivTick();
    wr(3'b111);
    wr(3'b001);
    gapToTick(g);
    chk("R6 old period completes", g + 2, 6);
    gapToTick(g);
    chk("R6 last write applied", g, 4);

    // R5, R7: mid-period write completes old period (ratio 4 -> 10)
    waitDivTick();
    cyc();
    wr(3'b111);
    gapToTick(g);
    chk("R5 mid-period write deferred", g + 2, 4);
    gapToTick(g);
    chk("R7 new ratio applied", g, 10);

    // R8: divide -> reference switch at period end
    waitDivTick();
    refAuto = 1'b0;
    cyc();
    wr(3'b011);
    repeat (7) cyc();
    chk("R5 still divided before end", refActive, 0);
    cyc();
    chk("R8 reference active after end", refActive, 1);
    chk("R8 busClk low on switch", busClk, 0);
    repeat (6) cyc();
    chk("R9 busClk held without tick", busClk, 0);
    chk("R9 stays on reference", refActive, 1);

    // R5, R7: reference -> divide only on a low-phase tick
    wr(3'b100);
    repeat (4) cyc();
    chk("R5 waits for reference tick", refActive, 1);
    refForce = 1'b1;
    cyc();
    refForce = 1'b0;
    cyc();
    chk("R7 divided after tick", refActive, 0);
    chk("R7 tick starts period", busTick, 1);
    chk("R7 busClk high at start", busClk, 1);
    measure(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule